// File: doc/BRIEF.md
# Reversible-Gate Two-to-Four Line Decoder

This block turns a two-bit select value into four one-hot lines. It builds the decode from modelled reversible primitives rather than from AND and NOT minterm logic. There are four primitives: a three-line controlled swap, a three-line TR cell, a two-line controlled-NOT and an inverter. Each primitive has as many outputs as inputs. Two ancilla inputs are tied to zero by the integrator. The one line that carries no result leaves the block on its own garbage port.

The netlist uses no direct fan-out of any gate output. The swap cell passes its control value through unchanged, and that copy feeds the TR cell. The swap's AND term goes through the controlled-NOT, which hands it back on its pass-through line. The only signal that reaches two gates is the primary input `selY`, and it is split at the block boundary. A static output reports the summed quantum cost of the primitives used: 5 + 4 + 1 + 0 = 10.

The block is purely combinational. It is used wherever a small address or phase field has to select one of four lines, and a reversible-style netlist is wanted.

Top module: `rev_dec2to4`

## Requirements
- R1: With both ancilla bits at 0, output line `decOut[i]` is high exactly when `{selX, selY}` equals i. So bit 0 is X'Y', bit 1 is X'Y, bit 2 is XY' and bit 3 is XY.
- R2: For every one of the four select values, exactly one bit of `decOut` is high.
- R3: `garbageOut` always carries the value of `selX`, copied through both the swap cell and the TR cell.
- R4: `qCost` reads the constant 10, which is the sum of the swap (5), TR (4), controlled-NOT (1) and inverter (0) costs.
- R5: The swap cell maps (a,b,c) to (a, a'b⊕ac, a'c⊕ab). All 8 input vectors give distinct output vectors.
- R6: The TR cell maps (a,b,c) to (a, a⊕b, ab'⊕c). All 8 input vectors give distinct output vectors.
- R7: The controlled-NOT maps (a,b) to (a, a⊕b), and the inverter maps a to a'. Each is distinct over its full input space.
- R8: When both `selX` and `selY` change in the same step, the outputs settle in that step to the new one-hot code, and the old line drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| selX | input | 1 | Select bit X (most significant) |
| selY | input | 1 | Select bit Y (least significant) |
| ancZero | input | 2 | Constant ancilla lines; must be held at 0 |
| decOut | output | 4 | One-hot decoded lines, index {X,Y} |
| garbageOut | output | 1 | Unused reversible output (copy of X) |
| qCost | output | 8 | Static total quantum cost (10) |

## Verification
The TR cell's XOR result and the swap cell's AND product are produced in the same evaluation. They meet at the controlled-NOT, and both the X'Y' line and the XY line depend on that meeting. The bench sets this up by flipping both select bits at once: from 01 to 10, and from 00 to 11 and back. After each flip it checks that the new code is one-hot and that no stale line stays high. Every primitive is also swept on its own over its full input space. Each output vector is compared with the algebraic mapping and recorded, so any repeated output vector is reported.

// File: rtl/rev_dec_pkg.sv
package rev_dec_pkg;
  localparam int unsigned CostSwap  = 5;
  localparam int unsigned CostTr    = 4;
  localparam int unsigned CostCnot  = 1;
  localparam int unsigned CostInv   = 0;
  localparam int unsigned CostTotal = CostSwap + CostTr + CostCnot + CostInv;
  localparam int unsigned CostW     = 8;
  localparam int unsigned SelW      = 2;
  localparam int unsigned LineN     = 1 << SelW;
  localparam int unsigned AncN      = 2;
endpackage

// File: rtl/rev_cswap.sv
module rev_cswap (
  input  logic ctlIn,
  input  logic dataB,
  input  logic dataC,
  output logic ctlOut,
  output logic outQ,
  output logic outR
);
  always_comb begin
    ctlOut = ctlIn;
    outQ   = ctlIn ? dataC : dataB;
    outR   = ctlIn ? dataB : dataC;
  end

  // R5: a swap only moves ones around, it never creates or destroys them
  always_comb begin
    p_swap_conserve_r5: assert ($countones({ctlOut, outQ, outR}) ==
                                $countones({ctlIn, dataB, dataC}))
      else $error("swap changed population count");
  end
endmodule

// File: rtl/rev_tr.sv
module rev_tr (
  input  logic lineA,
  input  logic lineB,
  input  logic lineC,
  output logic outP,
  output logic outQ,
  output logic outR
);
  always_comb begin
    outP = lineA;
    outQ = lineA ^ lineB;
    outR = (lineA & ~lineB) ^ lineC;
  end
endmodule

// File: rtl/rev_cnot.sv
module rev_cnot (
  input  logic lineA,
  input  logic lineB,
  output logic outP,
  output logic outQ
);
  always_comb begin
    outP = lineA;
    outQ = lineA ^ lineB;
  end
endmodule

// File: rtl/rev_inv.sv
module rev_inv (
  input  logic lineA,
  output logic outY
);
  assign outY = ~lineA;
endmodule

// File: rtl/rev_dec2to4.sv
module rev_dec2to4
  import rev_dec_pkg::*;
(
  input  logic                selX,
  input  logic                selY,
  input  logic [AncN-1:0]     ancZero,
  output logic [LineN-1:0]    decOut,
  output logic                garbageOut,
  output logic [CostW-1:0]    qCost
);
  // every gate output below drives exactly one load
  logic swX, swXnY, swXY;
  logic trX, trXor, trXnY;
  logic invXnor;
  logic cnXY, cnNone;

  rev_cswap uSwap (
    .ctlIn (selX),   .dataB (selY),  .dataC (ancZero[0]),
    .ctlOut(swX),    .outQ  (swXnY), .outR  (swXY)
  );

  rev_tr uTr (
    .lineA(swX),  .lineB(selY),  .lineC(ancZero[1]),
    .outP (trX),  .outQ (trXor), .outR (trXnY)
  );

  rev_inv uInv (
    .lineA(trXor), .outY(invXnor)
  );

  rev_cnot uCnot (
    .lineA(swXY), .lineB(invXnor),
    .outP (cnXY), .outQ (cnNone)
  );

  assign decOut     = {cnXY, trXnY, swXnY, cnNone};
  assign garbageOut = trX;
  assign qCost      = CostW'(CostTotal);

  always_comb begin
    if (ancZero == '0) begin
      p_one_hot_r2: assert ($onehot(decOut))
        else $error("decode not one-hot");
      p_line_sel_r1: assert (decOut[{selX, selY}])
        else $error("selected line low");
      p_garbage_x_r3: assert (garbageOut == selX)
        else $error("garbage line differs from X");
    end
    p_cost_ten_r4: assert (qCost == CostW'(CostSwap + CostTr + CostCnot + CostInv))
      else $error("cost constant wrong");
  end
endmodule

// File: tb/tb_rev_dec2to4.sv
module tb_rev_dec2to4;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int nCmp = 0;
  int nBad = 0;

  logic       selX, selY;
  logic [1:0] ancZero;
  logic [3:0] decOut;
  logic       garbageOut;
  logic [7:0] qCost;

  rev_dec2to4 dut (
    .selX(selX), .selY(selY), .ancZero(ancZero),
    .decOut(decOut), .garbageOut(garbageOut), .qCost(qCost)
  );

  // standalone primitives for the full-space sweeps
  logic [2:0] swIn, swOut, trIn, trOut;
  logic [1:0] cnIn, cnOut;
  logic       ivIn, ivOut;
  rev_cswap pSwap (.ctlIn(swIn[2]), .dataB(swIn[1]), .dataC(swIn[0]),
                   .ctlOut(swOut[2]), .outQ(swOut[1]), .outR(swOut[0]));
  rev_tr    pTr   (.lineA(trIn[2]), .lineB(trIn[1]), .lineC(trIn[0]),
                   .outP(trOut[2]), .outQ(trOut[1]), .outR(trOut[0]));
  rev_cnot  pCnot (.lineA(cnIn[1]), .lineB(cnIn[0]),
                   .outP(cnOut[1]), .outQ(cnOut[0]));
  rev_inv   pInv  (.lineA(ivIn), .outY(ivOut));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applySel(input logic x, input logic y);
    @(posedge clk);
    selX = x; selY = y;
    @(negedge clk);
  endtask

  task automatic test_start_r4;
    @(negedge clk);
    check(qCost == 8'd10, "R4 cost", qCost, 10);
  endtask

  task automatic test_decode_r1;
    for (int v = 0; v < 4; v++) begin
      applySel(v[1], v[0]);
      check(decOut == 4'(1 << v), "R1 decode", decOut, 1 << v);
      check($countones(decOut) == 1, "R2 one-hot", $countones(decOut), 1);
      check(garbageOut == v[1], "R3 garbage", garbageOut, v[1]);
    end
  endtask

  task automatic test_double_flip_r8;
    applySel(1'b0, 1'b1);
    applySel(1'b1, 1'b0);
    check(decOut == 4'b0100, "R8 01->10", decOut, 4);
    applySel(1'b0, 1'b0);
    applySel(1'b1, 1'b1);
    check(decOut == 4'b1000, "R8 00->11", decOut, 8);
    applySel(1'b0, 1'b0);
    check(decOut == 4'b0001, "R8 11->00", decOut, 1);
  endtask

  task automatic test_swap_r5;
    bit [7:0] seen = '0;
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      logic [2:0] exp;
      swIn = 3'(v);
      #1;
      a = v[2]; b = v[1]; c = v[0];
      exp = {a, (~a & b) ^ (a & c), (~a & c) ^ (a & b)};
      check(swOut == exp, "R5 swap map", swOut, exp);
      check(!seen[swOut], "R5 swap distinct", swOut, -1);
      seen[swOut] = 1'b1;
    end
  endtask

  task automatic test_tr_r6;
    bit [7:0] seen = '0;
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      logic [2:0] exp;
      trIn = 3'(v);
      #1;
      a = v[2]; b = v[1]; c = v[0];
      exp = {a, a ^ b, (a & ~b) ^ c};
      check(trOut == exp, "R6 tr map", trOut, exp);
      check(!seen[trOut], "R6 tr distinct", trOut, -1);
      seen[trOut] = 1'b1;
    end
  endtask

  task automatic test_cnot_inv_r7;
    bit [3:0] seen = '0;
    bit [1:0] seenInv = '0;
    for (int v = 0; v < 4; v++) begin
      logic [1:0] exp;
      cnIn = 2'(v);
      #1;
      exp = {v[1], v[1] ^ v[0]};
      check(cnOut == exp, "R7 cnot map", cnOut, exp);
      check(!seen[cnOut], "R7 cnot distinct", cnOut, -1);
      seen[cnOut] = 1'b1;
    end
    for (int v = 0; v < 2; v++) begin
      ivIn = v[0];
      #1;
      check(ivOut == ~v[0], "R7 inv map", ivOut, ~v[0]);
      check(!seenInv[ivOut], "R7 inv distinct", ivOut, -1);
      seenInv[ivOut] = 1'b1;
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    selX = 1'b0; selY = 1'b0; ancZero = 2'b00;
    swIn = '0; trIn = '0; cnIn = '0; ivIn = 1'b0;
    test_start_r4();
    test_decode_r1();
    test_double_flip_r8();
    test_swap_r5();
    test_tr_r6();
    test_cnot_inv_r7();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule